// File: doc/BRIEF.md
# Paired-Word Transfer Sequencer

This block runs the double-word load and double-word store operations of a 32-bit core. A single start pulse comes in with a direction select, a base value, a signed 16-bit displacement and an even register index. The block then makes two word transfers over a single-port memory handshake. An even/odd register pair moves between the register file and two adjacent aligned words.

The pairing crosses the usual register order. The lower word (at the aligned address) belongs to the odd register, and the upper word (address + 4) belongs to the even register. A load returns two write-backs, each one an index and a data word, and the core applies them to its register file. Because of the load delay, the core must not read the loaded pair in the slot right after the operation. An odd index is refused: the block raises an illegal flag and touches no memory.

Top module: `pair_xfer_seq`

## Requirements
- R1: The transfer address is the base plus the sign-extended displacement, modulo 2^32, with bits 1:0 forced to zero. The upper word sits at that address plus 4, also modulo 2^32.
- R2: A load first reads the aligned address and then the aligned address + 4. `memWe` is 0 for both reads.
- R3: For a load, the word read from the aligned address is written back to index `regIdx | 1`, and the word read from address + 4 is written back to `regIdx`. Each write-back is a one-cycle `wbEn` pulse in the cycle after its `memReady`.
- R4: A store first writes `dataEven` to address + 4 and then writes `dataOdd` to the aligned address, with `memWe` = 1. A store raises no `wbEn`.
- R5: While `memReady` is low, `memReq`, `memAddr`, `memWdata` and `memWe` hold their values.
- R6: A start with `regIdx[0]` = 1 gives `done` and `illegal` together for one cycle, in the cycle after the start. No `memReq` and no `wbEn` are raised.
- R7: `done` is a one-cycle pulse in the cycle after the second `memReady`. `busy` is high from the cycle after an accepted start through the `done` cycle, and low otherwise.
- R8: A `start` that arrives while `busy` is high is ignored. The running transfer keeps its addresses, data and index.
- R9: After reset, `busy`, `done`, `illegal`, `memReq`, `memWe` and `wbEn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; taken only when idle |
| isStore | input | 1 | 1 = store pair, 0 = load pair |
| baseVal | input | 32 | Base register value |
| offsetImm | input | 16 | Signed displacement |
| regIdx | input | 5 | Even register index of the pair |
| dataEven | input | 32 | Store value of register `regIdx` |
| dataOdd | input | 32 | Store value of register `regIdx+1` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Odd index refused (with `done`) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memReady | input | 1 | Memory accepts or completes the access |
| memRdata | input | 32 | Read data, valid with `memReady` |
| wbEn | output | 1 | Register write-back strobe |
| wbIdx | output | 5 | Write-back register index |
| wbData | output | 32 | Write-back data |

## Verification
The hardest case to reach from the ports is a new `start` that lands while an access is stalled. The block must not recapture its inputs in that cycle. The stimulus holds `memReady` low for several cycles and pulses `start` with an odd index and a different base during the stall. It then checks that the addresses, the write-backs and the absence of `illegal` all follow the first operation. Wrapping addresses at the top of the space, and negative displacements with a misaligned base, are driven so that the alignment mask and the +4 step are exercised across the carry.

// File: rtl/pair_xfer_pkg.sv
package pair_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_FINISH,
    ST_REFUSE
  } xferState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;      // latch operation inputs
    logic secondPhase;  // selects second access address/data
    logic wbFire;       // load word returned this cycle
  } xferStrobe_t;

endpackage

// File: rtl/pair_xfer_ctrl.sv
module pair_xfer_ctrl
  import pair_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        startOdd,
  input  logic        storeQ,
  input  logic        memReady,
  output xferStrobe_t strobe,
  output logic        memReq,
  output logic        busy,
  output logic        done,
  output logic        illegal
);

  xferState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (start) stateD = startOdd ? ST_REFUSE : ST_FIRST;
      ST_FIRST:  if (memReady) stateD = ST_SECOND;
      ST_SECOND: if (memReady) stateD = ST_FINISH;
      ST_FINISH: stateD = ST_IDLE;
      ST_REFUSE: stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign memReq  = (stateQ == ST_FIRST) || (stateQ == ST_SECOND);
  assign busy    = (stateQ != ST_IDLE);
  assign done    = (stateQ == ST_FINISH) || (stateQ == ST_REFUSE);
  assign illegal = (stateQ == ST_REFUSE);

  always_comb begin
    strobe.capture     = (stateQ == ST_IDLE) && start;
    strobe.secondPhase = (stateQ == ST_SECOND);
    strobe.wbFire      = memReq && memReady && !storeQ;
  end

endmodule

// File: rtl/pair_xfer_dp.sv
module pair_xfer_dp
  import pair_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 16,
  parameter int REG_W      = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strobe,
  input  logic              isStore,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  offsetImm,
  input  logic [REG_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] dataEven,
  input  logic [DATA_W-1:0] dataOdd,
  input  logic              memReq,
  input  logic [DATA_W-1:0] memRdata,
  output logic              storeQ,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              wbEn,
  output logic [REG_W-1:0]  wbIdx,
  output logic [DATA_W-1:0] wbData
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] WORD_STEP  = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] sextOff, eaD, eaQ;
  logic [REG_W-1:0]  idxQ;
  logic [DATA_W-1:0] evenQ, oddQ;

  assign sextOff = {{(ADDR_W-IMM_W){offsetImm[IMM_W-1]}}, offsetImm};
  assign eaD     = (baseVal + sextOff) & ALIGN_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaQ    <= '0;
      idxQ   <= '0;
      evenQ  <= '0;
      oddQ   <= '0;
      storeQ <= 1'b0;
    end else if (strobe.capture) begin
      eaQ    <= eaD;
      idxQ   <= regIdx;
      evenQ  <= dataEven;
      oddQ   <= dataOdd;
      storeQ <= isStore;
    end
  end

  // Upper word is touched first for stores, second for loads
  logic upperSel;
  assign upperSel = strobe.secondPhase ^ storeQ;
  assign memAddr  = upperSel ? (eaQ + WORD_STEP) : eaQ;
  assign memWdata = strobe.secondPhase ? oddQ : evenQ;
  assign memWe    = memReq && storeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbEn   <= 1'b0;
      wbIdx  <= '0;
      wbData <= '0;
    end else begin
      wbEn <= strobe.wbFire;
      if (strobe.wbFire) begin
        wbIdx  <= strobe.secondPhase ? idxQ : {idxQ[REG_W-1:1], 1'b1};
        wbData <= memRdata;
      end
    end
  end

endmodule

// File: rtl/pair_xfer_seq.sv
module pair_xfer_seq
  import pair_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 16,
  parameter int REG_W      = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isStore,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  offsetImm,
  input  logic [REG_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] dataEven,
  input  logic [DATA_W-1:0] dataOdd,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic              wbEn,
  output logic [REG_W-1:0]  wbIdx,
  output logic [DATA_W-1:0] wbData
);

  xferStrobe_t strobe;
  logic        storeQ;

  pair_xfer_ctrl ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .startOdd (regIdx[0]),
    .storeQ   (storeQ),
    .memReady (memReady),
    .strobe   (strobe),
    .memReq   (memReq),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal)
  );

  pair_xfer_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W),
    .REG_W(REG_W), .WORD_BYTES(WORD_BYTES)
  ) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .isStore   (isStore),
    .baseVal   (baseVal),
    .offsetImm (offsetImm),
    .regIdx    (regIdx),
    .dataEven  (dataEven),
    .dataOdd   (dataOdd),
    .memReq    (memReq),
    .memRdata  (memRdata),
    .storeQ    (storeQ),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .wbEn      (wbEn),
    .wbIdx     (wbIdx),
    .wbData    (wbData)
  );

endmodule

// File: rtl/pair_xfer_chk.sv
module pair_xfer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memReady,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              wbEn,
  input logic              busy,
  input logic              done,
  input logic              illegal
);

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWdata) && $stable(memWe))); // R5

  AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> $past(memReq && memReady && !memWe)); // R3

  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> !wbEn); // R4

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (done && !memReq && !wbEn)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R7

endmodule

bind pair_xfer_seq pair_xfer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chkInst (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memReady(memReady), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .wbEn(wbEn), .busy(busy),
  .done(done), .illegal(illegal)
);

// File: tb/pair_xfer_seq_test.sv
`timescale 1ns/1ps
module pair_xfer_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, isStore = 1'b0;
  logic [31:0] baseVal = '0, dataEven = '0, dataOdd = '0, memRdata = '0;
  logic [15:0] offsetImm = '0;
  logic [4:0]  regIdx = '0;
  logic        memReady = 1'b0;
  logic        busy, done, illegal, memReq, memWe, wbEn;
  logic [31:0] memAddr, memWdata, wbData;
  logic [4:0]  wbIdx;

  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  pair_xfer_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .isStore(isStore), .baseVal(baseVal),
    .offsetImm(offsetImm), .regIdx(regIdx), .dataEven(dataEven), .dataOdd(dataOdd),
    .busy(busy), .done(done), .illegal(illegal), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata),
    .wbEn(wbEn), .wbIdx(wbIdx), .wbData(wbData)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Behavioural model of one operation, checked on every clock (negedge).
  task automatic runOp(input bit st, input logic [31:0] base, input logic [15:0] off,
                       input logic [4:0] idx, input logic [31:0] dEven, input logic [31:0] dOdd,
                       input int lat0, input int lat1, input bit poke);
    logic [31:0] ea, addrs[2], wdat[2];
    logic [4:0]  wbi[2];
    int lats[2];
    ea = (base + {{16{off[15]}}, off}) & 32'hFFFF_FFFC;
    lats[0] = lat0; lats[1] = lat1;
    if (st) begin addrs[0] = ea + 32'd4; addrs[1] = ea; end
    else    begin addrs[0] = ea; addrs[1] = ea + 32'd4; end
    wdat[0] = dEven; wdat[1] = dOdd;
    wbi[0] = idx | 5'd1; wbi[1] = idx;
    @(negedge clk);
    start = 1'b1; isStore = st; baseVal = base; offsetImm = off;
    regIdx = idx; dataEven = dEven; dataOdd = dOdd;
    @(negedge clk);
    start = 1'b0;
    if (idx[0]) begin
      chk(done && illegal && busy, "R6 done/illegal pulse", {busy, done, illegal}, 3'b111);
      chk(!memReq && !wbEn, "R6 no access", {memReq, wbEn}, 2'b00);
      @(negedge clk);
      chk(!busy && !done && !illegal, "R6 back idle", {busy, done, illegal}, 3'b000);
      return;
    end
    for (int a = 0; a < 2; a++) begin
      for (int w = 0; w <= lats[a]; w++) begin
        chk(memReq && busy && !done, "R7 busy during access", {memReq, busy, done}, 3'b110);
        chk(memAddr == addrs[a], a == 0 ? "R1 R2 R4 first address" : "R1 R2 R4 second address",
            memAddr, addrs[a]);
        chk(memWe == st, "R2 R4 write enable", memWe, st);
        if (st) chk(memWdata == wdat[a], "R4 store data", memWdata, wdat[a]);
        if (w > 0) chk(!illegal, "R8 no illegal from ignored start", illegal, 0);
        memReady = (w == lats[a]);
        memRdata = (w == lats[a]) ? memWord(memAddr) : 32'hDEAD_BEEF;
        // R8: start pulse with odd index and other base while busy
        start = poke && (a == 0) && (w == 0);
        if (start) begin regIdx = idx | 5'd1; baseVal = base ^ 32'h0F0F_0000; isStore = !st; end
        @(negedge clk);
        start = 1'b0; memReady = 1'b0;
      end
      if (st) chk(!wbEn, "R4 no write-back on store", wbEn, 0);
      else begin
        chk(wbEn, "R3 write-back strobe", wbEn, 1);
        chk(wbIdx == wbi[a], "R3 write-back index", wbIdx, wbi[a]);
        chk(wbData == memWord(addrs[a]), "R3 write-back data", wbData, memWord(addrs[a]));
      end
    end
    chk(done && busy && !illegal && !memReq, "R7 done pulse", {done, busy, illegal, memReq}, 4'b1100);
    @(negedge clk);
    chk(!done && !busy && !wbEn && !memReq, "R7 idle after done", {done, busy, wbEn, memReq}, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, illegal, memReq, memWe, wbEn} == 6'b0, "R9 reset outputs",
        {busy, done, illegal, memReq, memWe, wbEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, done, illegal, memReq, memWe, wbEn} == 6'b0, "R9 idle after reset",
        {busy, done, illegal, memReq, memWe, wbEn}, 0);
    runOp(0, 32'h0000_1000, 16'h0008, 5'd4,  32'h0, 32'h0, 0, 0, 0);            // R2 R3 basic load
    runOp(0, 32'h0000_2003, 16'hFFFB, 5'd6,  32'h0, 32'h0, 2, 1, 0);            // R1 negative offset
    runOp(1, 32'h0000_0300, 16'h7FFF, 5'd10, 32'hAAAA_0001, 32'hBBBB_0002, 1, 3, 0); // R4 R5
    runOp(1, 32'hFFFF_FFFE, 16'h0004, 5'd2,  32'h1111_1111, 32'h2222_2222, 0, 0, 0); // R1 wrap
    runOp(0, 32'hFFFF_FFF8, 16'h0004, 5'd30, 32'h0, 32'h0, 0, 2, 0);            // R1 upper wraps to 0
    runOp(0, 32'h0000_4000, 16'h0000, 5'd7,  32'h0, 32'h0, 0, 0, 0);            // R6 odd load
    runOp(1, 32'h0000_4000, 16'h0010, 5'd31, 32'h5, 32'h6, 0, 0, 0);            // R6 odd store
    runOp(0, 32'h0000_8000, 16'h0020, 5'd12, 32'h0, 32'h0, 3, 1, 1);            // R8 load poke
    runOp(1, 32'h0000_9004, 16'hFFF0, 5'd0,  32'hCAFE_0000, 32'hF00D_0000, 4, 0, 1); // R8 store poke
    runOp(0, 32'h1234_5678, 16'h8000, 5'd20, 32'h0, 32'h0, 1, 1, 0);            // R1 most negative
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule